// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Master Sequencer

This block is a synchronous master for an external bus that carries the address and the data on the same wires. It signals in the style that uses a separate read/write level and a single data strobe. Four strobes control an access: an address latch pulse, an active-low chip select, a read/write level (high means read) and an active-low data strobe. Because the bus wires are shared, the block gives a separate output value, drive enable and input value for them, and the pad ring joins these.

Internal logic issues one access at a time through a request port. The port carries the address, the write data and the direction. The block returns a one-cycle done pulse, with captured read data for reads. Five timing fields set the length of each bus phase in bus clock cycles: address, data setup, strobe, hold and recovery. A field value of n gives n+1 cycles. The block takes a copy of the fields when it accepts a request, so the whole access runs with one set of timing.

Top module: `mux_bus_seq`

## Requirements
- R1: After a request is accepted, `bus_ale` is high for exactly `cfg_t1`+1 cycles, starting in the cycle after acceptance. In those cycles `bus_oe` is high and `bus_out` carries the address.
- R2: In the single cycle after `bus_ale` falls, the address stays driven with `bus_oe` high. `bus_cs_n` goes low in that same cycle.
- R3: Next come `cfg_t2`+1 setup cycles with `bus_ds_n` high and `bus_cs_n` low. On a write, `bus_out` carries the write data with `bus_oe` high.
- R4: Next `bus_ds_n` stays low for `cfg_t3`+1 cycles. On a write, the write data stays driven for that whole time.
- R5: Next come `cfg_t4`+1 hold cycles with `bus_ds_n` high. `bus_cs_n` stays low and `bus_rw` keeps its level. On a write, the write data stays driven.
- R6: On a read, `bus_oe` is low from the first setup cycle through the last hold cycle. `rdata` takes the value of `bus_in` at the end of the last strobe cycle.
- R7: `done` is high only during the last hold cycle, for one cycle per access. On a read, `rdata` holds the captured value in that cycle.
- R8: After the hold phase, `cfg_t5`+1 recovery cycles follow with the bus idle and `req_ready` low. `req_ready` is high only in idle. A request is taken only when `req_valid` and `req_ready` are both high. Requests made while busy have no effect.
- R9: The timing fields are sampled at acceptance. Changing them during an access does not alter that access.
- R10: During reset and after it, the bus is idle: `bus_ale`=0, `bus_cs_n`=1, `bus_ds_n`=1, `bus_rw`=1, `bus_oe`=0, `done`=0 and `req_ready`=1.
- R11: `bus_rw` is 0 for a write and 1 for a read from the address phase through the hold phase. It is 1 when the bus is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, able to take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | BW | Access address |
| req_wdata | input | BW | Write data |
| cfg_t1 | input | T1_W | Address phase length minus one |
| cfg_t2 | input | PH_W | Data setup length minus one |
| cfg_t3 | input | PH_W | Strobe length minus one |
| cfg_t4 | input | PH_W | Hold length minus one |
| cfg_t5 | input | PH_W | Recovery length minus one |
| done | output | 1 | Access complete pulse |
| rdata | output | BW | Captured read data |
| bus_ale | output | 1 | Address latch enable |
| bus_cs_n | output | 1 | Chip select, active low |
| bus_rw | output | 1 | 1 = read, 0 = write |
| bus_ds_n | output | 1 | Data strobe, active low |
| bus_out | output | BW | Value driven on the shared wires |
| bus_oe | output | 1 | Drive enable for the shared wires |
| bus_in | input | BW | Value seen on the shared wires |

## Verification
A state machine that runs a phase one cycle too long or too short shifts the next edge of `bus_ale`, `bus_cs_n` or `bus_ds_n`. The per-cycle comparison reports this in the first cycle that is off, well before `done` appears. A fault in the capture or the snapshot shows up later. A wrong capture cycle shows as bad `rdata` at the done pulse. The stimulus puts valid read data on `bus_in` only in the last strobe cycle. A timing field read live instead of from the snapshot shows as a phase length that follows the junk values the bench applies during the access. A request that is wrongly taken while busy puts a second `bus_ale` pulse inside the recovery window.

// File: rtl/mbs_pkg.sv
package mbs_pkg;
  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_ADDR   = 3'd1,
    ST_AHOLD  = 3'd2,
    ST_SETUP  = 3'd3,
    ST_STROBE = 3'd4,
    ST_HOLD   = 3'd5,
    ST_RECOV  = 3'd6
  } mbs_state_e;

  localparam int unsigned N_SNAP = 4;
endpackage

// File: rtl/mbs_phase_timer.sv
module mbs_phase_timer #(
  parameter int unsigned CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          expired
);
  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = load || (cnt_q != '0);
    cnt_d  = cnt_q;
    if (load) cnt_d = load_val;
    else if (cnt_q != '0) cnt_d = cnt_q - CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign expired = (cnt_q == '0);

  // R8: an idle counter does not wake up without a load
  a_r8_timer_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (expired && !load) |=> expired);
endmodule

// File: rtl/mbs_ctrl.sv
module mbs_ctrl
  import mbs_pkg::*;
#(
  parameter int unsigned T1_W = 2,
  parameter int unsigned PH_W = 4,
  localparam int unsigned CW = (PH_W > T1_W) ? PH_W : T1_W
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          req_valid,
  input  logic [T1_W-1:0]               cfg_t1,
  input  logic [N_SNAP-1:0][PH_W-1:0]   snap_ph,
  input  logic                          wr_q,
  input  logic                          expired,
  output mbs_state_e                    state,
  output logic                          tmr_load,
  output logic [CW-1:0]                 tmr_val,
  output logic                          accept,
  output logic                          capture,
  output logic                          done,
  output logic                          ready,
  output logic                          ale,
  output logic                          cs_n,
  output logic                          ds_n
);
  mbs_state_e state_q, state_d;

  always_comb begin
    state_d  = state_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    accept   = 1'b0;
    capture  = 1'b0;
    done     = 1'b0;
    unique case (state_q)
      ST_IDLE: if (req_valid) begin
        accept   = 1'b1;
        state_d  = ST_ADDR;
        tmr_load = 1'b1;
        tmr_val  = CW'(cfg_t1);
      end
      ST_ADDR: if (expired) state_d = ST_AHOLD;
      ST_AHOLD: begin
        state_d  = ST_SETUP;
        tmr_load = 1'b1;
        tmr_val  = CW'(snap_ph[0]);
      end
      ST_SETUP: if (expired) begin
        state_d  = ST_STROBE;
        tmr_load = 1'b1;
        tmr_val  = CW'(snap_ph[1]);
      end
      ST_STROBE: if (expired) begin
        state_d  = ST_HOLD;
        tmr_load = 1'b1;
        tmr_val  = CW'(snap_ph[2]);
        capture  = !wr_q;
      end
      ST_HOLD: if (expired) begin
        done     = 1'b1;
        state_d  = ST_RECOV;
        tmr_load = 1'b1;
        tmr_val  = CW'(snap_ph[3]);
      end
      ST_RECOV: if (expired) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign state = state_q;
  assign ready = (state_q == ST_IDLE);
  assign ale   = (state_q == ST_ADDR);
  assign cs_n  = !((state_q == ST_AHOLD) || (state_q == ST_SETUP) ||
                   (state_q == ST_STROBE) || (state_q == ST_HOLD));
  assign ds_n  = (state_q != ST_STROBE);

  // R1: address latch pulse never exceeds four cycles
  a_r1_ale_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    (ale && $past(ale) && $past(ale, 2) && $past(ale, 3)) |=> !ale);
  // R2: chip select asserted right after the latch pulse ends
  a_r2_cs_after_ale: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ale) |-> !cs_n);
  // R7: done is a single-cycle pulse
  a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R8: recovery is never followed directly by an address phase
  a_r8_recov_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RECOV) |=> !ale);
endmodule

// File: rtl/mbs_datapath.sv
module mbs_datapath
  import mbs_pkg::*;
#(
  parameter int unsigned BW   = 16,
  parameter int unsigned PH_W = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        accept,
  input  logic                        capture,
  input  mbs_state_e                  state,
  input  logic                        req_write,
  input  logic [BW-1:0]               req_addr,
  input  logic [BW-1:0]               req_wdata,
  input  logic [N_SNAP-1:0][PH_W-1:0] cfg_ph,
  input  logic [BW-1:0]               bus_in,
  output logic [N_SNAP-1:0][PH_W-1:0] snap_ph,
  output logic                        wr_q,
  output logic [BW-1:0]               rdata,
  output logic [BW-1:0]               bus_out,
  output logic                        bus_oe,
  output logic                        bus_rw
);
  logic [BW-1:0] addr_q, wdata_q, rdata_q;
  logic          addr_phase, data_phase;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
      wr_q    <= 1'b0;
    end else if (accept) begin
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
      wr_q    <= req_write;
    end
  end

  for (genvar g = 0; g < N_SNAP; g++) begin : g_snap
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      snap_ph[g] <= '0;
      else if (accept) snap_ph[g] <= cfg_ph[g];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rdata_q <= '0;
    else if (capture) rdata_q <= bus_in;
  end

  assign addr_phase = (state == ST_ADDR) || (state == ST_AHOLD);
  assign data_phase = (state == ST_SETUP) || (state == ST_STROBE) || (state == ST_HOLD);
  assign bus_out    = addr_phase ? addr_q : wdata_q;
  assign bus_oe     = addr_phase || (data_phase && wr_q);
  assign bus_rw     = (addr_phase || data_phase) ? !wr_q : 1'b1;
  assign rdata      = rdata_q;

  // R9: timing snapshot only moves on acceptance
  a_r9_snap_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |=> $stable(snap_ph));
  // R6: read data only moves on a capture
  a_r6_rdata_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !capture |=> $stable(rdata_q));
endmodule

// File: rtl/mux_bus_seq.sv
module mux_bus_seq
  import mbs_pkg::*;
#(
  parameter int unsigned BW   = 16,
  parameter int unsigned T1_W = 2,
  parameter int unsigned PH_W = 4,
  localparam int unsigned CW = (PH_W > T1_W) ? PH_W : T1_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic            req_write,
  input  logic [BW-1:0]   req_addr,
  input  logic [BW-1:0]   req_wdata,
  input  logic [T1_W-1:0] cfg_t1,
  input  logic [PH_W-1:0] cfg_t2,
  input  logic [PH_W-1:0] cfg_t3,
  input  logic [PH_W-1:0] cfg_t4,
  input  logic [PH_W-1:0] cfg_t5,
  output logic            done,
  output logic [BW-1:0]   rdata,
  output logic            bus_ale,
  output logic            bus_cs_n,
  output logic            bus_rw,
  output logic            bus_ds_n,
  output logic [BW-1:0]   bus_out,
  output logic            bus_oe,
  input  logic [BW-1:0]   bus_in
);
  logic                        rst_meta, rst_sync;
  logic [N_SNAP-1:0][PH_W-1:0] cfg_ph, snap_ph;
  mbs_state_e                  state;
  logic                        tmr_load, expired, accept, capture, wr_q;
  logic [CW-1:0]               tmr_val;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sync <= rst_meta;
    end
  end

  assign cfg_ph = {cfg_t5, cfg_t4, cfg_t3, cfg_t2};

  mbs_phase_timer #(.CW(CW)) u_tmr (
    .clk(clk), .rst_n(rst_sync), .load(tmr_load), .load_val(tmr_val), .expired(expired)
  );

  mbs_ctrl #(.T1_W(T1_W), .PH_W(PH_W)) u_ctrl (
    .clk(clk), .rst_n(rst_sync), .req_valid(req_valid), .cfg_t1(cfg_t1),
    .snap_ph(snap_ph), .wr_q(wr_q), .expired(expired), .state(state),
    .tmr_load(tmr_load), .tmr_val(tmr_val), .accept(accept), .capture(capture),
    .done(done), .ready(req_ready), .ale(bus_ale), .cs_n(bus_cs_n), .ds_n(bus_ds_n)
  );

  mbs_datapath #(.BW(BW), .PH_W(PH_W)) u_dp (
    .clk(clk), .rst_n(rst_sync), .accept(accept), .capture(capture), .state(state),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .cfg_ph(cfg_ph), .bus_in(bus_in), .snap_ph(snap_ph), .wr_q(wr_q),
    .rdata(rdata), .bus_out(bus_out), .bus_oe(bus_oe), .bus_rw(bus_rw)
  );

  // R6: the block never drives the wires while a read strobe is active
  a_r6_read_released: assert property (@(posedge clk) disable iff (!rst_sync)
    (!bus_ds_n && bus_rw) |-> !bus_oe);
  // R4: the data strobe only appears inside chip select
  a_r4_ds_in_cs: assert property (@(posedge clk) disable iff (!rst_sync)
    !bus_ds_n |-> !bus_cs_n);
  // R11: direction is held steady while chip select is low
  a_r11_rw_steady: assert property (@(posedge clk) disable iff (!rst_sync)
    (!bus_cs_n && $past(!bus_cs_n)) |-> $stable(bus_rw));
endmodule

// File: tb/sim_mux_bus_seq.sv
module sim_mux_bus_seq;
  localparam int BW = 16;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, req_valid, req_ready, req_write, done;
  logic bus_ale, bus_cs_n, bus_rw, bus_ds_n, bus_oe;
  logic [BW-1:0] req_addr, req_wdata, rdata, bus_out, bus_in;
  logic [1:0] cfg_t1;
  logic [3:0] cfg_t2, cfg_t3, cfg_t4, cfg_t5;

  int n_cmp = 0;
  int n_bad = 0;

  mux_bus_seq u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .cfg_t1(cfg_t1), .cfg_t2(cfg_t2), .cfg_t3(cfg_t3), .cfg_t4(cfg_t4), .cfg_t5(cfg_t5),
    .done(done), .rdata(rdata), .bus_ale(bus_ale), .bus_cs_n(bus_cs_n),
    .bus_rw(bus_rw), .bus_ds_n(bus_ds_n), .bus_out(bus_out), .bus_oe(bus_oe),
    .bus_in(bus_in)
  );

  task automatic cmp(string tag, logic [BW-1:0] act, logic [BW-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic expect_cycle(string req, bit ale, bit cs_n, bit ds_n, bit rw, bit oe,
                              logic [BW-1:0] outv, bit dn, bit rdy);
    cmp({req, " ale"},   BW'(bus_ale),   BW'(ale));
    cmp({req, " cs_n"},  BW'(bus_cs_n),  BW'(cs_n));
    cmp({req, " ds_n"},  BW'(bus_ds_n),  BW'(ds_n));
    cmp({req, " R11 rw"}, BW'(bus_rw),   BW'(rw));
    cmp({req, " oe"},    BW'(bus_oe),    BW'(oe));
    cmp({req, " done"},  BW'(done),      BW'(dn));
    cmp({req, " ready"}, BW'(req_ready), BW'(rdy));
    if (oe) cmp({req, " out"}, bus_out, outv);
  endtask

  // apply junk to request and timing inputs while busy (R8, R9)
  task automatic noise(logic [BW-1:0] good);
    req_valid = 1'b1;
    req_write = 1'($urandom);
    req_addr  = BW'($urandom);
    req_wdata = BW'($urandom);
    cfg_t1    = 2'($urandom);
    cfg_t2    = 4'($urandom);
    cfg_t3    = 4'($urandom);
    cfg_t4    = 4'($urandom);
    cfg_t5    = 4'($urandom);
    bus_in    = ~good;
  endtask

  // one full access: accept, phases, recovery; reference timeline built from the fields
  task automatic access(bit wr, logic [BW-1:0] a, logic [BW-1:0] wd,
                        int t1, int t2, int t3, int t4, int t5);
    logic [BW-1:0] good;
    bit rw;
    good = a ^ 16'h5A3C;
    rw   = !wr;
    @(negedge clk);
    expect_cycle("R8 idle", 0, 1, 1, 1, 0, '0, 0, 1);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = wd;
    cfg_t1 = 2'(t1); cfg_t2 = 4'(t2); cfg_t3 = 4'(t3); cfg_t4 = 4'(t4); cfg_t5 = 4'(t5);
    bus_in = ~good;
    for (int i = 0; i <= t1; i++) begin
      @(negedge clk);
      expect_cycle("R1 addr", 1, 1, 1, rw, 1, a, 0, 0);
      noise(good);
    end
    @(negedge clk);
    expect_cycle("R2 ahold", 0, 0, 1, rw, 1, a, 0, 0);
    noise(good);
    for (int i = 0; i <= t2; i++) begin
      @(negedge clk);
      expect_cycle(wr ? "R3 setup" : "R6 setup", 0, 0, 1, rw, wr, wd, 0, 0);
      noise(good);
    end
    for (int i = 0; i <= t3; i++) begin
      @(negedge clk);
      expect_cycle(wr ? "R4 strobe" : "R6 strobe", 0, 0, 0, rw, wr, wd, 0, 0);
      noise(good);
      if (i == t3) bus_in = good;
    end
    for (int i = 0; i <= t4; i++) begin
      @(negedge clk);
      expect_cycle(i == t4 ? "R7 hold" : "R5 hold", 0, 0, 1, rw, wr, wd, i == t4, 0);
      if (i == t4 && !wr) cmp("R6 R7 rdata", rdata, good);
      noise(good);
    end
    for (int i = 0; i <= t5; i++) begin
      @(negedge clk);
      expect_cycle("R8 recov", 0, 1, 1, 1, 0, '0, 0, 0);
      noise(good);
      if (i == t5) req_valid = 1'b0;
    end
  endtask

  initial begin
    #(20 * 200000);
    n_bad++;
    $display("FAIL watchdog expired act=running exp=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_wdata = '0;
    cfg_t1 = '0; cfg_t2 = '0; cfg_t3 = '0; cfg_t4 = '0; cfg_t5 = '0; bus_in = '0;
    repeat (3) @(negedge clk);
    expect_cycle("R10 in reset", 0, 1, 1, 1, 0, '0, 0, 1);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    expect_cycle("R10 after reset", 0, 1, 1, 1, 0, '0, 0, 1);
    cmp("R10 rdata", rdata, '0);

    access(1, 16'h1234, 16'hBEEF, 0, 0, 0, 0, 0);
    access(0, 16'h0F0F, 16'h0000, 0, 0, 0, 0, 0);
    access(1, 16'hA55A, 16'hC3C3, 3, 15, 15, 15, 15);
    access(0, 16'h8001, 16'h0000, 3, 15, 15, 15, 15);
    access(0, 16'h4242, 16'h0000, 1, 2, 3, 4, 5);
    access(1, 16'h7777, 16'h1111, 2, 5, 1, 7, 0);
    for (int k = 0; k < 20; k++)
      access(1'($urandom), BW'($urandom), BW'($urandom), int'($urandom % 4),
             int'($urandom % 16), int'($urandom % 16), int'($urandom % 16), int'($urandom % 16));
    @(negedge clk);
    expect_cycle("R8 final idle", 0, 1, 1, 1, 0, '0, 0, 1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule